// File: doc/BRIEF.md
# Memory Return Sequencer

This block sits on the return side of a memory-side cache and serializes everything that comes back from memory. It keeps one current item. When it is free, it picks the next item from three sources: the head of the active merged-miss chain, the read-return stream, and the write-return stream. A response taken from memory is announced to the miss tracker, which may activate a chain of merged requests for that line. If a chain becomes active, its first request replaces the raw response as the current item.

For a read, the sequencer offers reply data upstream. In the cycle the reply is accepted, it issues a combined probe-and-fill lookup to the cache. If the lookup evicts a dirty line, the victim address is latched and a full-line writeback is offered downstream until it is accepted. No new item is taken while that writeback is pending. A write response retires without touching the reply or the cache.

All data streams use valid/ready. A transfer takes place on a rising edge where both are high. Once raised, the sequencer's `rep_valid` and `wb_valid` stay high with stable payload until accepted. The inputs `chain_vld`, `rd_rsp_valid` and `wr_rsp_valid` are level "available" signals: the sequencer pops by raising the matching ready or pop output in that cycle. The notification and lookup pins are plain single-cycle strobes.

Top module: `ret_seq`

## Requirements
- R1: During reset and in the first cycle after it, `rep_valid`, `wb_valid`, `done_valid`, `lookup_valid`, `svc_valid`, `chain_pop`, `rd_rsp_ready` and `wr_rsp_ready` are all low.
- R2: When no item is current and `chain_vld` is high, the sequencer pops the chain (`chain_pop`=1) and neither return stream is popped, even if both have data.
- R3: With no item current and the chain empty, the read-return stream is popped in preference to the write-return stream. At most one of the three sources is popped in any cycle.
- R4: In the cycle a response is popped from either return stream, `svc_valid` is 1 and `svc_addr` equals that response's address.
- R5: If `chain_vld` is high in the cycle after a response was popped, the chain head is popped and becomes the current item. The reply then carries the chain head's id and address, not the response's.
- R6: A current read drives `rep_valid`=1 with its address and id. While `rep_ready` is 0, the reply stays valid and stable, and no lookup and no retirement occur.
- R7: In the cycle a read reply is accepted, `lookup_valid`=1 with `lookup_addr` equal to the reply address. If `lookup_present`=1 or `lookup_victim` is all-ones (no victim), the item retires in that same cycle (`done_valid`=1, `done_write`=0, `done_id` = item id).
- R8: If a lookup reports `lookup_present`=0 and a victim other than all-ones, then from the next cycle `wb_valid`=1 with `wb_addr` = victim. `wb_bytes` equals LINE_BYTES and `wb_hdr_bytes` equals LINE_BYTES+RDPKT_BYTES. The writeback is held until `wb_ready`, and the item retires in the accept cycle.
- R9: While a writeback is pending, no source is popped.
- R10: A current write item retires two cycles after its pop from the write stream, or one cycle after a chain pop, with `done_write`=1 and no reply or lookup.
- R11: A pending victim (writeback valid) is never present while the sequencer holds no current item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_vld | input | 1 | Active merged-miss chain is non-empty |
| chain_pop | output | 1 | Pop chain head this cycle |
| chain_addr | input | ADDR_W | Chain head address |
| chain_id | input | ID_W | Chain head request id |
| chain_write | input | 1 | Chain head is a write |
| rd_rsp_valid | input | 1 | Read-return stream has data |
| rd_rsp_ready | output | 1 | Pop read-return stream |
| rd_rsp_addr | input | ADDR_W | Read response address |
| rd_rsp_id | input | ID_W | Read response id |
| wr_rsp_valid | input | 1 | Write-return stream has data |
| wr_rsp_ready | output | 1 | Pop write-return stream |
| wr_rsp_addr | input | ADDR_W | Write response address |
| wr_rsp_id | input | ID_W | Write response id |
| svc_valid | output | 1 | Response-serviced notification to miss tracker |
| svc_addr | output | ADDR_W | Address of serviced response |
| rep_valid | output | 1 | Reply data valid upstream |
| rep_ready | input | 1 | Upstream reply queue has space |
| rep_addr | output | ADDR_W | Reply address |
| rep_id | output | ID_W | Reply request id |
| lookup_valid | output | 1 | Probe-and-fill strobe to cache |
| lookup_addr | output | ADDR_W | Lookup address |
| lookup_present | input | 1 | Line already present, no fill |
| lookup_victim | input | ADDR_W | Evicted dirty line address, all-ones if none |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback queue has room |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_bytes | output | SZ_W | Writeback payload size (one line) |
| wb_hdr_bytes | output | SZ_W | Writeback header size (line plus read packet) |
| done_valid | output | 1 | Current item retired |
| done_id | output | ID_W | Id of retired item |
| done_write | output | 1 | Retired item was a write |

## Verification
The hardest case is the replacement of a freshly popped response by the chain it activates. It depends on `chain_vld` rising exactly in the cycle after the pop, while the response is already latched. The bench raises the chain signal at that point only, and checks that the reply carries the chain head's id. A second hard case is a dirty eviction whose writeback is refused for several cycles while new read responses are already waiting. The bench holds `wb_ready` low with `rd_rsp_valid` high, and confirms that nothing is popped and the writeback stays stable until it is accepted.

// File: rtl/ret_seq_pkg.sv
package ret_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_EXEC = 2'd2,
    ST_WB   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ret_src_pick.sv
module ret_src_pick #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              recheck,
  input  logic              chain_vld,
  input  logic [ADDR_W-1:0] chain_addr,
  input  logic [ID_W-1:0]   chain_id,
  input  logic              chain_write,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ID_W-1:0]   rd_id,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ID_W-1:0]   wr_id,
  output logic              chain_pop,
  output logic              rd_pop,
  output logic              wr_pop,
  output logic              load,
  output logic              from_mem,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [ID_W-1:0]   ld_id,
  output logic              ld_write
);
  always_comb begin
    chain_pop = (idle || recheck) && chain_vld;
    rd_pop    = idle && !chain_vld && rd_vld;
    wr_pop    = idle && !chain_vld && !rd_vld && wr_vld;
    from_mem  = rd_pop || wr_pop;
    load      = chain_pop || from_mem;
    if (chain_pop) begin
      ld_addr = chain_addr; ld_id = chain_id; ld_write = chain_write;
    end else if (rd_pop) begin
      ld_addr = rd_addr; ld_id = rd_id; ld_write = 1'b0;
    end else begin
      ld_addr = wr_addr; ld_id = wr_id; ld_write = 1'b1;
    end
  end

  // R3
  one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chain_pop, rd_pop, wr_pop}));
endmodule

// File: rtl/ret_victim_hold.sv
module ret_victim_hold #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 128,
  parameter int RDPKT_BYTES = 8,
  parameter int SZ_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SZ_W-1:0]   wb_bytes,
  output logic [SZ_W-1:0]   wb_hdr_bytes
);
  localparam logic [ADDR_W-1:0] NO_VICTIM = '1;
  logic [ADDR_W-1:0] victim_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   victim_q <= NO_VICTIM;
    else if (load)                victim_q <= load_addr;
    else if (wb_valid && wb_ready) victim_q <= NO_VICTIM;
  end

  assign wb_valid     = (victim_q != NO_VICTIM);
  assign wb_addr      = victim_q;
  assign wb_bytes     = SZ_W'(LINE_BYTES);
  assign wb_hdr_bytes = SZ_W'(LINE_BYTES + RDPKT_BYTES);

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
endmodule

// File: rtl/ret_seq.sv
module ret_seq
  import ret_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 8,
  parameter int LINE_BYTES  = 128,
  parameter int RDPKT_BYTES = 8,
  localparam int SZ_W       = $clog2(LINE_BYTES + RDPKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_vld,
  output logic              chain_pop,
  input  logic [ADDR_W-1:0] chain_addr,
  input  logic [ID_W-1:0]   chain_id,
  input  logic              chain_write,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [ADDR_W-1:0] rd_rsp_addr,
  input  logic [ID_W-1:0]   rd_rsp_id,
  input  logic              wr_rsp_valid,
  output logic              wr_rsp_ready,
  input  logic [ADDR_W-1:0] wr_rsp_addr,
  input  logic [ID_W-1:0]   wr_rsp_id,
  output logic              svc_valid,
  output logic [ADDR_W-1:0] svc_addr,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [ADDR_W-1:0] rep_addr,
  output logic [ID_W-1:0]   rep_id,
  output logic              lookup_valid,
  output logic [ADDR_W-1:0] lookup_addr,
  input  logic              lookup_present,
  input  logic [ADDR_W-1:0] lookup_victim,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SZ_W-1:0]   wb_bytes,
  output logic [SZ_W-1:0]   wb_hdr_bytes,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic              done_write
);
  localparam logic [ADDR_W-1:0] NO_VICTIM = '1;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [ID_W-1:0]   cur_id_q;
  logic              cur_write_q;

  logic              load, from_mem, ld_write;
  logic [ADDR_W-1:0] ld_addr;
  logic [ID_W-1:0]   ld_id;
  logic              need_wb, victim_load;

  ret_src_pick #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .idle(state_q == ST_IDLE), .recheck(state_q == ST_CHK),
    .chain_vld(chain_vld), .chain_addr(chain_addr), .chain_id(chain_id),
    .chain_write(chain_write),
    .rd_vld(rd_rsp_valid), .rd_addr(rd_rsp_addr), .rd_id(rd_rsp_id),
    .wr_vld(wr_rsp_valid), .wr_addr(wr_rsp_addr), .wr_id(wr_rsp_id),
    .chain_pop(chain_pop), .rd_pop(rd_rsp_ready), .wr_pop(wr_rsp_ready),
    .load(load), .from_mem(from_mem),
    .ld_addr(ld_addr), .ld_id(ld_id), .ld_write(ld_write)
  );

  assign svc_valid    = from_mem;
  assign svc_addr     = ld_addr;
  assign rep_valid    = (state_q == ST_EXEC) && !cur_write_q;
  assign rep_addr     = cur_addr_q;
  assign rep_id       = cur_id_q;
  assign lookup_valid = rep_valid && rep_ready;
  assign lookup_addr  = cur_addr_q;
  assign need_wb      = !lookup_present && (lookup_victim != NO_VICTIM);
  assign victim_load  = lookup_valid && need_wb;
  assign done_valid   = ((state_q == ST_EXEC) && cur_write_q)
                      || (lookup_valid && !need_wb)
                      || ((state_q == ST_WB) && wb_valid && wb_ready);
  assign done_id      = cur_id_q;
  assign done_write   = cur_write_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      cur_id_q    <= '0;
      cur_write_q <= 1'b0;
    end else begin
      if (load) begin
        cur_addr_q  <= ld_addr;
        cur_id_q    <= ld_id;
        cur_write_q <= ld_write;
      end
      unique case (state_q)
        ST_IDLE: if (from_mem) state_q <= ST_CHK;
                 else if (chain_pop) state_q <= ST_EXEC;
        ST_CHK:  state_q <= ST_EXEC;
        ST_EXEC: if (cur_write_q) state_q <= ST_IDLE;
                 else if (rep_ready) state_q <= need_wb ? ST_WB : ST_IDLE;
        ST_WB:   if (wb_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ret_victim_hold #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
                    .RDPKT_BYTES(RDPKT_BYTES), .SZ_W(SZ_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .load(victim_load), .load_addr(lookup_victim),
    .wb_ready(wb_ready), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_bytes(wb_bytes), .wb_hdr_bytes(wb_hdr_bytes)
  );

  // R11
  victim_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> state_q == ST_WB);
  // R9
  wb_blocks_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !chain_pop && !rd_rsp_ready && !wr_rsp_ready);
  // R6
  rep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_id) && $stable(rep_addr));
  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_write |-> !rep_valid && !lookup_valid);
endmodule

// File: tb/tb_ret_seq.sv
module tb_ret_seq;
  localparam int AW = 32, IW = 8;
  logic clk = 0, rst_n = 0;
  logic chain_vld = 0, chain_write = 0, rd_rsp_valid = 0, wr_rsp_valid = 0;
  logic [AW-1:0] chain_addr = 0, rd_rsp_addr = 0, wr_rsp_addr = 0, lookup_victim = '1;
  logic [IW-1:0] chain_id = 0, rd_rsp_id = 0, wr_rsp_id = 0;
  logic rep_ready = 0, lookup_present = 1, wb_ready = 0;
  logic chain_pop, rd_rsp_ready, wr_rsp_ready, svc_valid, rep_valid, lookup_valid;
  logic wb_valid, done_valid, done_write;
  logic [AW-1:0] svc_addr, rep_addr, lookup_addr, wb_addr;
  logic [IW-1:0] rep_id, done_id;
  logic [7:0] wb_bytes, wb_hdr_bytes;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ret_seq dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic quiet();
    chain_vld = 0; rd_rsp_valid = 0; wr_rsp_valid = 0;
    rep_ready = 0; wb_ready = 0; lookup_present = 1; lookup_victim = '1;
  endtask

  task automatic t_reset();
    chk("R1 rep_valid", rep_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 done_valid", done_valid, 0);
    @(negedge clk); rst_n = 1; #2;
    chk("R1 pops", {chain_pop, rd_rsp_ready, wr_rsp_ready, svc_valid, lookup_valid}, 0);
  endtask

  task automatic t_read_then_write();
    rd_rsp_valid = 1; rd_rsp_addr = 32'h100; rd_rsp_id = 5;
    wr_rsp_valid = 1; wr_rsp_addr = 32'h200; wr_rsp_id = 9;
    #1;
    chk("R3 rd first", {rd_rsp_ready, wr_rsp_ready}, 2'b10);
    chk("R4 svc_valid", svc_valid, 1);
    chk("R4 svc_addr", svc_addr, 32'h100);
    step(); rd_rsp_valid = 0; #1;
    chk("R3 chk no pop", wr_rsp_ready, 0);
    step();
    chk("R6 rep_valid", rep_valid, 1);
    chk("R6 rep_id", rep_id, 5);
    chk("R6 no lookup", lookup_valid, 0);
    step();
    chk("R6 still valid", {rep_valid, rep_addr}, {1'b1, 32'h100});
    chk("R6 no done", done_valid, 0);
    rep_ready = 1; #1;
    chk("R7 lookup", {lookup_valid, lookup_addr}, {1'b1, 32'h100});
    chk("R7 done", {done_valid, done_write, done_id}, {2'b10, 8'd5});
    step(); rep_ready = 0; #1;
    chk("R3 wr taken", {wr_rsp_ready, svc_addr}, {1'b1, 32'h200});
    step(); wr_rsp_valid = 0; #1;
    step();
    chk("R10 write retire", {done_valid, done_write, done_id}, {2'b11, 8'd9});
    chk("R10 no reply", {rep_valid, lookup_valid}, 0);
    step();
    chk("R10 idle after", done_valid, 0);
  endtask

  task automatic t_chain_first();
    chain_vld = 1; chain_addr = 32'h340; chain_id = 7; chain_write = 0;
    rd_rsp_valid = 1; rd_rsp_addr = 32'h500; rd_rsp_id = 1;
    #1;
    chk("R2 chain pop", {chain_pop, rd_rsp_ready, wr_rsp_ready}, 3'b100);
    chk("R2 no svc", svc_valid, 0);
    step(); chain_vld = 0; rd_rsp_valid = 0; #1;
    chk("R2 rep id", {rep_valid, rep_id}, {1'b1, 8'd7});
    rep_ready = 1; lookup_present = 0; lookup_victim = '1; #1;
    chk("R7 miss no victim retires", {done_valid, done_id}, {1'b1, 8'd7});
    step(); quiet(); #1;
    chk("R7 no wb", wb_valid, 0);
  endtask

  task automatic t_chain_replace();
    rd_rsp_valid = 1; rd_rsp_addr = 32'h600; rd_rsp_id = 3;
    #1; chk("R4 svc", {svc_valid, svc_addr}, {1'b1, 32'h600});
    step(); rd_rsp_valid = 0;
    chain_vld = 1; chain_addr = 32'h610; chain_id = 11; chain_write = 0; #1;
    chk("R5 chain pop after svc", chain_pop, 1);
    step(); chain_vld = 0; #1;
    chk("R5 replaced id", rep_id, 11);
    chk("R5 replaced addr", rep_addr, 32'h610);
    rep_ready = 1; #1;
    chk("R5 retire chain head", {done_valid, done_id}, {1'b1, 8'd11});
    step(); quiet();
  endtask

  task automatic t_evict();
    rd_rsp_valid = 1; rd_rsp_addr = 32'h700; rd_rsp_id = 4;
    step(); rd_rsp_valid = 0;
    step();
    rep_ready = 1; lookup_present = 0; lookup_victim = 32'h1000; #1;
    chk("R8 lookup not retired", {lookup_valid, done_valid}, 2'b10);
    step(); rep_ready = 0; lookup_victim = '1;
    rd_rsp_valid = 1; rd_rsp_addr = 32'h800; rd_rsp_id = 6; #1;
    chk("R8 wb valid", {wb_valid, wb_addr}, {1'b1, 32'h1000});
    chk("R8 wb bytes", wb_bytes, 128);
    chk("R8 wb hdr", wb_hdr_bytes, 136);
    chk("R9 no pop", {chain_pop, rd_rsp_ready, wr_rsp_ready}, 0);
    step();
    chk("R8 wb held", {wb_valid, wb_addr}, {1'b1, 32'h1000});
    chk("R9 still no pop", rd_rsp_ready, 0);
    wb_ready = 1; #1;
    chk("R8 retire on accept", {done_valid, done_id}, {1'b1, 8'd4});
    step(); wb_ready = 0; #1;
    chk("R11 wb cleared", wb_valid, 0);
    chk("R9 pop resumes", rd_rsp_ready, 1);
    step(); rd_rsp_valid = 0;
    step(); rep_ready = 1; #1;
    chk("R7 next read", {done_valid, done_id}, {1'b1, 8'd6});
    step(); quiet();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_read_then_write();
    t_chain_first();
    t_chain_replace();
    t_evict();
    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule